// File: doc/BRIEF.md
# Hot Loop Mode Controller

This block watches resolved branches coming out of the first execute stage. It decides when the front end should start recording a loop body into a loop buffer, and when it should replay that body from the buffer instead of fetching it from instruction memory. The processor has no branch predictor, so the controller acts only on outcomes that are already final. Each outcome arrives as a branch PC, a valid strobe and a taken bit.

A small direct-mapped table, indexed by the low PC bits and tagged with the rest, keeps two values for each branch: a taken count and a hot flag. When a branch has been taken a threshold number of times, the entry becomes hot and the controller raises a one-cycle record pulse. The next time that hot branch is taken, the controller raises the replay mode. Replay mode is dropped in three cases: the loop buffer reports a miss, a hot branch falls through, or another branch is promoted and starts a new recording.

The branch strobe is a plain valid with no ready. The execute stage cannot be held back, so every strobe is consumed in the cycle it appears. Both mode outputs are registered. Each one reflects the inputs sampled at the previous rising edge.

Top module: `hot_loop_mode_ctrl`

## Requirements
- R1: A synchronous reset drives `store_mode` and `fetch_mode` low and empties the table. After reset, every branch must again be taken THRESHOLD times before it is promoted.
- R2: A branch that is absent from the table is treated as having count 0 and hot flag 0. An untaken outcome of a branch that is not hot changes neither its count nor the mode outputs.
- R3: Each taken outcome of a branch that is not hot adds one to its count. While the new count is below THRESHOLD (default 4), both mode outputs keep their values and `store_mode` stays low.
- R4: The taken outcome that brings the count to THRESHOLD marks the entry hot and drives `store_mode` high for exactly the following cycle.
- R5: A taken outcome of a hot branch drives `fetch_mode` high from the following cycle, and it stays high until a clearing event occurs. The count of a hot entry stays at THRESHOLD.
- R6: A `lb_miss` in a cycle drives `fetch_mode` low in the following cycle. This takes priority over a hot-taken outcome in the same cycle.
- R7: An untaken outcome of a hot branch drives `fetch_mode` low in the following cycle.
- R8: A promotion (R4) of any branch drives `fetch_mode` low in the same cycle in which `store_mode` rises.
- R9: `store_mode` and `fetch_mode` are never high in the same cycle.
- R10: The table has ENTRIES slots indexed by PC bits [log2(ENTRIES)-1:0] and tagged with the remaining bits. A taken outcome of a branch whose slot holds another tag replaces that entry, and the replacement starts its count at 1.
- R11: In a cycle with neither a branch strobe nor a miss, `fetch_mode` holds its value and `store_mode` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A resolved branch is presented this cycle |
| br_pc | input | PC_W | PC of the resolved branch |
| br_taken | input | 1 | Outcome of the resolved branch, 1 = taken |
| lb_miss | input | 1 | Loop buffer could not supply the requested instruction |
| store_mode | output | 1 | One-cycle pulse: record the next instructions into the loop buffer |
| fetch_mode | output | 1 | Supply instructions from the loop buffer |

## Verification
A corrupted count or tag in the table does not show up at once. It surfaces only when the affected branch is next taken: the record pulse or the replay mode then arrives one taken outcome too early or too late, or not at all. A wrong mode register, in contrast, is visible one cycle after the event that should have set or cleared it. For this reason the bench compares both outputs against its model after every cycle. It also replays sequences long enough for a stale count to reach the threshold at the wrong point.

// File: rtl/hl_pkg.sv
package hl_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_COUNT,
    ACT_PROMOTE,
    ACT_HOT_TAKEN,
    ACT_HOT_UNTAKEN
  } hl_act_e;
endpackage

// File: rtl/hl_bit_table.sv
module hl_bit_table #(
  parameter int PC_W    = 16,
  parameter int ENTRIES = 16,
  parameter int CNT_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] rd_pc,
  output logic [CNT_W-1:0] rd_cnt,
  output logic            rd_hot,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic            wr_hot
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W;

  logic             slot_vld [ENTRIES];
  logic [TAG_W-1:0] slot_tag [ENTRIES];
  logic [CNT_W-1:0] slot_cnt [ENTRIES];
  logic             slot_hot [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             rd_hit;

  assign rd_idx = rd_pc[IDX_W-1:0];
  assign wr_idx = wr_pc[IDX_W-1:0];
  assign rd_hit = slot_vld[rd_idx] && (slot_tag[rd_idx] == rd_pc[PC_W-1:IDX_W]);

  // absent branches read back as all-zero information
  always_comb begin
    rd_cnt = rd_hit ? slot_cnt[rd_idx] : '0;
    rd_hot = rd_hit ? slot_hot[rd_idx] : 1'b0;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_vld[g] <= 1'b0;
        slot_tag[g] <= '0;
        slot_cnt[g] <= '0;
        slot_hot[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_vld[g] <= 1'b1;
        slot_tag[g] <= wr_pc[PC_W-1:IDX_W];
        slot_cnt[g] <= wr_cnt;
        slot_hot[g] <= wr_hot;
      end
    end
  end
endmodule

// File: rtl/hl_decide.sv
module hl_decide
  import hl_pkg::*;
#(
  parameter int THRESHOLD = 4,
  parameter int CNT_W     = 3
) (
  input  logic             br_valid,
  input  logic             br_taken,
  input  logic [CNT_W-1:0] cur_cnt,
  input  logic             cur_hot,
  output hl_act_e          act,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_cnt,
  output logic             wr_hot
);
  localparam logic [CNT_W:0] THR_EXT = (CNT_W+1)'(THRESHOLD);

  logic [CNT_W:0] inc;
  assign inc = {1'b0, cur_cnt} + 1'b1;

  always_comb begin
    act    = ACT_NONE;
    wr_en  = 1'b0;
    wr_cnt = cur_cnt;
    wr_hot = cur_hot;
    if (br_valid) begin
      if (cur_hot) begin
        act = br_taken ? ACT_HOT_TAKEN : ACT_HOT_UNTAKEN;
      end else if (br_taken) begin
        wr_en = 1'b1;
        if (inc >= THR_EXT) begin
          act    = ACT_PROMOTE;
          wr_cnt = THR_EXT[CNT_W-1:0];
          wr_hot = 1'b1;
        end else begin
          act    = ACT_COUNT;
          wr_cnt = inc[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/hl_mode_regs.sv
module hl_mode_regs
  import hl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  hl_act_e act,
  input  logic    lb_miss,
  output logic    store_mode,
  output logic    fetch_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      store_mode <= 1'b0;
      fetch_mode <= 1'b0;
    end else begin
      store_mode <= (act == ACT_PROMOTE);
      if (lb_miss) begin
        fetch_mode <= 1'b0;
      end else begin
        case (act)
          ACT_HOT_TAKEN:   fetch_mode <= 1'b1;
          ACT_HOT_UNTAKEN: fetch_mode <= 1'b0;
          ACT_PROMOTE:     fetch_mode <= 1'b0;
          default:         fetch_mode <= fetch_mode;
        endcase
      end
    end
  end
endmodule

// File: rtl/hot_loop_mode_ctrl.sv
module hot_loop_mode_ctrl
  import hl_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int ENTRIES   = 16,
  parameter int THRESHOLD = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            br_valid,
  input  logic [PC_W-1:0] br_pc,
  input  logic            br_taken,
  input  logic            lb_miss,
  output logic            store_mode,
  output logic            fetch_mode
);
  localparam int CNT_W = $clog2(THRESHOLD + 1);

  logic [CNT_W-1:0] cur_cnt, nxt_cnt;
  logic             cur_hot, nxt_hot, tbl_we;
  hl_act_e          act;

  hl_bit_table #(.PC_W(PC_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .rd_pc  (br_pc),
    .rd_cnt (cur_cnt),
    .rd_hot (cur_hot),
    .wr_en  (tbl_we),
    .wr_pc  (br_pc),
    .wr_cnt (nxt_cnt),
    .wr_hot (nxt_hot)
  );

  hl_decide #(.THRESHOLD(THRESHOLD), .CNT_W(CNT_W)) u_decide (
    .br_valid (br_valid),
    .br_taken (br_taken),
    .cur_cnt  (cur_cnt),
    .cur_hot  (cur_hot),
    .act      (act),
    .wr_en    (tbl_we),
    .wr_cnt   (nxt_cnt),
    .wr_hot   (nxt_hot)
  );

  hl_mode_regs u_modes (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .lb_miss    (lb_miss),
    .store_mode (store_mode),
    .fetch_mode (fetch_mode)
  );
endmodule

// File: rtl/hl_mode_chk.sv
module hl_mode_chk (
  input logic clk,
  input logic rst,
  input logic br_valid,
  input logic br_taken,
  input logic lb_miss,
  input logic store_mode,
  input logic fetch_mode
);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(store_mode && fetch_mode));

  a_r4_store_from_taken: assert property (@(posedge clk) disable iff (rst)
    br_valid && !br_taken |=> !store_mode);

  a_r6_miss_clears: assert property (@(posedge clk) disable iff (rst)
    lb_miss |=> !fetch_mode);

  a_r5_fetch_needs_taken: assert property (@(posedge clk) disable iff (rst)
    !fetch_mode && !(br_valid && br_taken) |=> !fetch_mode);

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !br_valid && !lb_miss |=> $stable(fetch_mode) && !store_mode);
endmodule

bind hot_loop_mode_ctrl hl_mode_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .br_valid   (br_valid),
  .br_taken   (br_taken),
  .lb_miss    (lb_miss),
  .store_mode (store_mode),
  .fetch_mode (fetch_mode)
);

// File: tb/hot_loop_mode_ctrl_tb.sv
module hot_loop_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16;
  localparam int ENT  = 16;
  localparam int THR  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br_valid = 1'b0;
  logic [PC_W-1:0] br_pc = '0;
  logic br_taken = 1'b0;
  logic lb_miss = 1'b0;
  logic store_mode, fetch_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int  m_tag [ENT];
  int  m_cnt [ENT];
  bit  m_vld [ENT];
  bit  m_hot [ENT];
  bit  e_store, e_fetch;

  always #(CLK_PERIOD/2) clk = ~clk;

  hot_loop_mode_ctrl #(.PC_W(PC_W), .ENTRIES(ENT), .THRESHOLD(THR)) u_dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_pc(br_pc),
    .br_taken(br_taken), .lb_miss(lb_miss),
    .store_mode(store_mode), .fetch_mode(fetch_mode)
  );

  function automatic void model_reset();
    for (int i = 0; i < ENT; i++) begin
      m_vld[i] = 0; m_tag[i] = 0; m_cnt[i] = 0; m_hot[i] = 0;
    end
    e_store = 0;
    e_fetch = 0;
  endfunction

  // behavioural model of one clock edge, written from the requirements
  function automatic void model_edge(bit v, int pc, bit t, bit miss);
    int idx = pc % ENT;
    int tg  = pc / ENT;
    bit hit = m_vld[idx] && (m_tag[idx] == tg);
    int cnt = hit ? m_cnt[idx] : 0;
    bit hot = hit ? m_hot[idx] : 0;
    bit promote = 0;
    bit nf = e_fetch;
    if (v && hot && t) nf = 1;
    if (v && hot && !t) nf = 0;
    if (v && !hot && t) begin
      m_vld[idx] = 1; m_tag[idx] = tg;
      if (cnt + 1 >= THR) begin
        m_cnt[idx] = THR; m_hot[idx] = 1; promote = 1; nf = 0;
      end else begin
        m_cnt[idx] = cnt + 1; m_hot[idx] = 0;
      end
    end
    if (miss) nf = 0;
    e_store = promote;
    e_fetch = nf;
  endfunction

  task automatic compare(string req);
    checks++;
    if (store_mode !== e_store || fetch_mode !== e_fetch) begin
      errors++;
      $display("FAIL %s: store/fetch actual %b/%b expected %b/%b at %0t",
               req, store_mode, fetch_mode, e_store, e_fetch, $time);
    end
  endtask

  task automatic step(bit v, int pc, bit t, bit miss, string req);
    br_valid = v;
    br_pc    = PC_W'(pc);
    br_taken = t;
    lb_miss  = miss;
    @(posedge clk);
    model_edge(v, pc, t, miss);
    @(negedge clk);
    br_valid = 0;
    lb_miss  = 0;
    compare(req);
  endtask

  task automatic do_reset(string req);
    rst = 1;
    br_valid = 0;
    lb_miss = 0;
    repeat (2) @(negedge clk);
    model_reset();
    rst = 0;
    compare(req);
  endtask

  localparam int PC_A = 'h0010;  // slot 0
  localparam int PC_B = 'h0021;  // slot 1
  localparam int PC_C = 'h0030;  // slot 0, other tag

  initial begin
    @(negedge clk);
    do_reset("R1 reset state");

    step(1, PC_A, 0, 0, "R2 unknown untaken");
    step(1, PC_A, 0, 0, "R2 untaken again");
    for (int i = 0; i < THR - 1; i++) step(1, PC_A, 1, 0, "R3 below threshold");
    step(1, PC_A, 0, 0, "R2 untaken keeps count");
    step(1, PC_A, 1, 0, "R4 promotion pulse");
    step(0, 0, 0, 0, "R4 pulse lasts one cycle");
    step(1, PC_A, 1, 0, "R5 hot taken sets fetch");
    step(0, 0, 0, 0, "R11 idle holds fetch");
    step(1, PC_A, 1, 0, "R5 hot stays hot");
    step(0, 0, 0, 1, "R6 miss clears fetch");
    step(1, PC_A, 1, 0, "R5 fetch again");
    step(1, PC_A, 0, 0, "R7 hot untaken clears");
    step(1, PC_A, 1, 0, "R5 fetch after fallthrough");
    for (int i = 0; i < THR - 1; i++) step(1, PC_B, 1, 0, "R3 other branch counting");
    step(1, PC_B, 1, 0, "R8 other promotion clears fetch R9");
    step(1, PC_A, 1, 1, "R6 miss beats hot taken");
    step(1, PC_B, 1, 0, "R5 second hot branch");
    step(1, PC_C, 1, 0, "R10 alias evicts");
    step(1, PC_A, 1, 0, "R10 evicted restarts count");
    for (int i = 0; i < THR - 2; i++) step(1, PC_A, 1, 0, "R10 recount");
    step(1, PC_A, 1, 0, "R10 repromoted");
    step(0, 0, 0, 0, "R11 idle store low");

    @(negedge clk);
    do_reset("R1 reset mid run");
    step(1, PC_B, 1, 0, "R1 table emptied");
    for (int i = 0; i < THR - 1; i++) step(1, PC_B, 1, 0, "R1 recount after reset");
    step(1, PC_B, 1, 0, "R5 hot after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule